// File: doc/BRIEF.md
# Interval Timer Count Snapshot and Read-Back Path

This block is the readout side of a three-channel programmable interval timer. It watches writes to the timer's control address and picks out the two snapshot commands. The first freezes the count of one counter. The second can freeze the count, the status, or both, for any subset of the three counters in a single write. Ordinary control words are also decoded here, because they set each counter's byte format and reprogramming clears any pending snapshot.

Each counter has an output latch. While free, the latch follows the live 16-bit count from the counting element. A count snapshot freezes it until the counter's whole count has been read back over the 8-bit bus in the programmed byte order. Each counter also has a status latch that holds a one-byte picture of its configuration and pin state. The read and write byte pointers are kept apart, so reads and loads of the same counter may be interleaved, and accesses to other counters may fall between the two bytes of a read.

The counting element and the output waveforms sit outside this block. Their live count, OUT level and null-count flag arrive as plain inputs. The read interface is a request/response pair. A one-cycle `rd_en` strobe is answered by `rd_valid` exactly one cycle later. The response cannot be stalled, so the requester must accept it in that cycle. Write strobes take effect at the clock edge where `wr_en` is high.

Top module: `pit_readout`

## Requirements
- R1: After reset, `rd_valid` is low and every `wr_byte_hi` bit is 0. No count or status is latched. Every counter is set for LSB-then-MSB access, mode 0, binary.
- R2: A write to address 3 whose D7:D6 is 00, 01 or 10 addresses counter 0, 1 or 2. If D5:D4 is 00, the write is a count-latch command and D3:D0 are ignored. Otherwise it is a control word: the access format is D5:D4 (01 LSB only, 10 MSB only, 11 LSB then MSB), the mode is D3:D1 and BCD is D0.
- R3: Once latched, a counter's reads return the count captured at the latch edge, even while the live count changes. A free counter's reads return the live count.
- R4: A count-latch request for a counter whose count is still latched and unread is ignored. The first captured value stays.
- R5: In the LSB-then-MSB format, the first read returns bits 7:0 and the second returns bits 15:8, and the second read releases the latch. Data writes and accesses to other counters between the two reads do not disturb the read byte order.
- R6: In the LSB-only or MSB-only format, a single read returns that byte and releases the latch.
- R7: A write to address 3 with D7:D6 = 11 is a read-back command. D5=0 requests a count latch and D4=0 requests a status latch. D3, D2 and D1 select counters 2, 1 and 0. If D0 is 1, the command is ignored entirely.
- R8: A read-back acts like a separate latch command for each selected counter. A counter is released only by reads of that counter; the other counters stay latched.
- R9: The status byte is {OUT, null-count, format[1:0], mode[2:0], BCD}, from bit 7 down to bit 0. It is captured only when no status is already pending for that counter.
- R10: While a status is pending, the next read of that counter returns the status byte and clears it. Later reads return the count in its programmed format.
- R11: A control word to a counter clears its pending count, its pending status and both of its byte pointers.
- R12: `rd_data` and `rd_valid` change one cycle after an `rd_en` strobe. A read of address 3 returns 0 and changes no state.
- R13: `wr_byte_hi[i]` toggles on each data write to counter i while that counter is in the LSB-then-MSB format. In the other formats it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 2 | Write address: 0..2 counter data, 3 control |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | Read request strobe |
| rd_addr | input | 2 | Read address |
| rd_valid | output | 1 | Read response valid, one cycle after rd_en |
| rd_data | output | 8 | Read response byte |
| cnt_live | input | NCH*16 | Live counts, counter i at bits [16i+15:16i] |
| out_lvl | input | NCH | OUT pin level of each counter |
| null_cnt | input | NCH | Null-count flag of each counter |
| wr_byte_hi | output | NCH | Next data write to counter i goes to its MSB |

## Verification
The bench builds the block with its default parameters: three counters, 8-bit bus bytes and 16-bit counts. With these values every command code and every counter-select bit can be reached, and the bench uses all three byte formats at once, one per counter. That setup makes it possible to interleave accesses between counters while one of them is half-read. It also lets a single read-back leave some counters latched while others are released.

// File: rtl/pit_rb_pkg.sv
package pit_rb_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = 2 * BYTE_W;

  typedef enum logic [1:0] {
    FMT_CMD  = 2'b00,
    FMT_LSB  = 2'b01,
    FMT_MSB  = 2'b10,
    FMT_BOTH = 2'b11
  } rw_fmt_e;

  typedef struct packed {
    logic    out;
    logic    nul;
    rw_fmt_e fmt;
    logic [2:0] mode;
    logic    bcd;
  } sts_byte_t;
endpackage

// File: rtl/pit_cmd_decode.sv
module pit_cmd_decode #(
  parameter int unsigned NCH = 3
) (
  input  logic           wr_en,
  input  logic [1:0]     wr_addr,
  input  logic [7:0]     wr_data,
  output logic [NCH-1:0] prog,
  output logic [NCH-1:0] grab_cnt,
  output logic [NCH-1:0] grab_sts,
  output logic [NCH-1:0] data_wr
);
  logic ctl_hit, rb_cmd, single_latch;

  always_comb begin
    ctl_hit      = wr_en && (wr_addr == 2'd3);
    rb_cmd       = ctl_hit && (wr_data[7:6] == 2'b11) && !wr_data[0];
    single_latch = ctl_hit && (wr_data[7:6] != 2'b11) && (wr_data[5:4] == 2'b00);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel;
    assign sel         = (wr_data[7:6] == 2'(i));
    assign prog[i]     = ctl_hit && sel && (wr_data[5:4] != 2'b00);
    assign grab_cnt[i] = (single_latch && sel) || (rb_cmd && !wr_data[5] && wr_data[1+i]);
    assign grab_sts[i] = rb_cmd && !wr_data[4] && wr_data[1+i];
    assign data_wr[i]  = wr_en && (wr_addr == 2'(i));
  end
endmodule

// File: rtl/pit_chan_latch.sv
module pit_chan_latch
  import pit_rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog,
  input  logic [5:0]        prog_bits,
  input  logic              grab_cnt,
  input  logic              grab_sts,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [CNT_W-1:0]  live,
  input  logic              out_lvl,
  input  logic              null_cnt,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              wr_hi
);
  rw_fmt_e          fmt_q;
  logic [2:0]       mode_q;
  logic             bcd_q;
  logic             cnt_held, sts_held, rd_hi;
  logic [CNT_W-1:0] ol_q;
  sts_byte_t        sts_q, sts_now;
  logic [CNT_W-1:0] src;
  logic             release_cnt;

  always_comb begin
    src     = cnt_held ? ol_q : live;
    sts_now = '{out: out_lvl, nul: null_cnt, fmt: fmt_q, mode: mode_q, bcd: bcd_q};
    release_cnt = 1'b0;
    if (sts_held) begin
      rd_byte = sts_q;
    end else begin
      unique case (fmt_q)
        FMT_LSB: begin rd_byte = src[BYTE_W-1:0];     release_cnt = 1'b1; end
        FMT_MSB: begin rd_byte = src[CNT_W-1:BYTE_W]; release_cnt = 1'b1; end
        default: begin
          rd_byte     = rd_hi ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
          release_cnt = rd_hi;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_q    <= FMT_BOTH;
      mode_q   <= '0;
      bcd_q    <= 1'b0;
      cnt_held <= 1'b0;
      sts_held <= 1'b0;
      rd_hi    <= 1'b0;
      wr_hi    <= 1'b0;
      ol_q     <= '0;
      sts_q    <= '0;
    end else if (prog) begin
      fmt_q    <= rw_fmt_e'(prog_bits[5:4]);
      mode_q   <= prog_bits[3:1];
      bcd_q    <= prog_bits[0];
      cnt_held <= 1'b0;
      sts_held <= 1'b0;
      rd_hi    <= 1'b0;
      wr_hi    <= 1'b0;
    end else begin
      if (rd_stb) begin
        if (sts_held) begin
          sts_held <= 1'b0;
        end else begin
          if (fmt_q == FMT_BOTH) rd_hi <= !rd_hi;
          if (release_cnt) cnt_held <= 1'b0;
        end
      end
      if (grab_cnt && !cnt_held) begin
        cnt_held <= 1'b1;
        ol_q     <= live;
      end
      if (grab_sts && !sts_held) begin
        sts_held <= 1'b1;
        sts_q    <= sts_now;
      end
      if (wr_stb) wr_hi <= (fmt_q == FMT_BOTH) ? !wr_hi : 1'b0;
    end
  end

  // R3
  held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_held && $past(cnt_held)) |-> $stable(ol_q));

  // R4
  regrab_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grab_cnt && cnt_held && !prog) |=> $stable(ol_q));

  // R10
  sts_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && sts_held) |=> !sts_held);

  // R11
  prog_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog |=> (!cnt_held && !sts_held && !rd_hi && !wr_hi));

  // R13
  wr_ptr_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_q != FMT_BOTH) |-> !wr_hi);
endmodule

// File: rtl/pit_readout.sv
module pit_readout
  import pit_rb_pkg::*;
#(
  parameter int unsigned NCH = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_addr,
  input  logic [7:0]           wr_data,
  input  logic                 rd_en,
  input  logic [1:0]           rd_addr,
  output logic                 rd_valid,
  output logic [7:0]           rd_data,
  input  logic [NCH*16-1:0]    cnt_live,
  input  logic [NCH-1:0]       out_lvl,
  input  logic [NCH-1:0]       null_cnt,
  output logic [NCH-1:0]       wr_byte_hi
);
  logic [NCH-1:0] prog, grab_cnt, grab_sts, data_wr, rd_stb;
  logic [BYTE_W-1:0] ch_byte [NCH];
  logic [BYTE_W-1:0] sel_byte;

  pit_cmd_decode #(.NCH(NCH)) u_dec (
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .prog     (prog),
    .grab_cnt (grab_cnt),
    .grab_sts (grab_sts),
    .data_wr  (data_wr)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign rd_stb[i] = rd_en && (rd_addr == 2'(i));
    pit_chan_latch u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .prog      (prog[i]),
      .prog_bits (wr_data[5:0]),
      .grab_cnt  (grab_cnt[i]),
      .grab_sts  (grab_sts[i]),
      .rd_stb    (rd_stb[i]),
      .wr_stb    (data_wr[i]),
      .live      (cnt_live[i*CNT_W +: CNT_W]),
      .out_lvl   (out_lvl[i]),
      .null_cnt  (null_cnt[i]),
      .rd_byte   (ch_byte[i]),
      .wr_hi     (wr_byte_hi[i])
    );
  end

  always_comb begin
    sel_byte = '0;
    for (int i = 0; i < NCH; i++)
      if (rd_addr == 2'(i)) sel_byte = ch_byte[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? sel_byte : '0;
    end
  end

  // R12
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));
endmodule

// File: tb/pit_readout_tb_top.sv
module pit_readout_tb_top;
  localparam int NCH = 3;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic rd_valid;
  logic [7:0] rd_data;
  logic [NCH*16-1:0] cnt_live = '0;
  logic [NCH-1:0] out_lvl = '0, null_cnt = '0;
  logic [NCH-1:0] wr_byte_hi;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] q_exp[$];
  string q_tag[$];

  always #10 clk = ~clk;

  pit_readout #(.NCH(NCH)) dut_i (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
    @(negedge clk); rd_en = 1; rd_addr = a;
    q_exp.push_back(exp); q_tag.push_back(tag);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic set_live(int ch, logic [15:0] v);
    @(negedge clk); cnt_live[ch*16 +: 16] = v;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rd_valid) begin
      if (q_exp.size() == 0) chk("R12 unexpected response", 8'hxx, 8'h00);
      else chk(q_tag.pop_front(), rd_data, q_exp.pop_front());
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rd_valid", {7'd0, rd_valid}, 8'h00);
    chk("R1 wr_byte_hi", {5'd0, wr_byte_hi}, 8'h00);
    // R1: default two-byte format, free latch follows live
    set_live(0, 16'hBEEF);
    rd(0, 8'hEF, "R1 default lsb");
    rd(0, 8'hBE, "R1 default msb");

    // R2/R3: program counters
    wr(3, 8'h34);  // ch0 LSB then MSB, mode 2
    wr(3, 8'h50);  // ch1 LSB only
    wr(3, 8'hA6);  // ch2 MSB only, mode 3
    set_live(0, 16'h1234);
    wr(3, 8'h0F);  // R2 latch ch0, low bits ignored
    set_live(0, 16'h5678);
    rd(0, 8'h34, "R3 latched lsb");
    rd(0, 8'h12, "R3 latched msb");
    rd(0, 8'h78, "R3 free lsb");
    rd(0, 8'h56, "R3 free msb");

    // R4: second latch ignored
    wr(3, 8'h00);
    set_live(0, 16'h9ABC);
    wr(3, 8'h00);
    rd(0, 8'h78, "R4 first capture lsb");
    rd(0, 8'h56, "R4 first capture msb");

    // R5/R13: interleave
    set_live(0, 16'h1111);
    set_live(1, 16'h22AB);
    set_live(2, 16'hCD12);
    wr(3, 8'h00);
    set_live(0, 16'h3333);
    rd(0, 8'h11, "R5 lsb");
    wr(0, 8'h55);
    @(negedge clk);
    chk("R13 toggle two-byte", {5'd0, wr_byte_hi}, 8'h01);
    wr(1, 8'h66);
    @(negedge clk);
    chk("R13 single format stays low", {5'd0, wr_byte_hi}, 8'h01);
    rd(1, 8'hAB, "R6 lsb only");
    rd(2, 8'hCD, "R6 msb only");
    rd(0, 8'h11, "R5 msb after interleave");
    rd(0, 8'h33, "R5 released");
    rd(0, 8'h33, "R5 released msb");

    // R6: single-byte latch released after one read
    wr(3, 8'h40);
    set_live(1, 16'h00CC);
    rd(1, 8'hAB, "R6 latched lsb only");
    rd(1, 8'hCC, "R6 released after one read");

    // R7/R8: read-back count only, all counters
    set_live(0, 16'h0102);
    set_live(1, 16'h0304);
    set_live(2, 16'h0506);
    wr(3, 8'hDE);
    cnt_live = {16'hF6F6, 16'hF4F4, 16'hF2F2};
    rd(1, 8'h04, "R8 ch1 latched");
    rd(2, 8'h05, "R8 ch2 latched");
    rd(2, 8'hF6, "R8 ch2 released");
    rd(0, 8'h02, "R8 ch0 still latched lsb");
    rd(0, 8'h01, "R8 ch0 still latched msb");
    // R7: reserved bit set -> ignored
    wr(3, 8'hDF);
    set_live(1, 16'h0077);
    rd(1, 8'h77, "R7 reserved bit ignored");

    // R9/R10: status only, ch1
    out_lvl = 3'b010; null_cnt = 3'b000;
    wr(3, 8'hE4);
    out_lvl = 3'b000; null_cnt = 3'b010;
    wr(3, 8'hE4);  // ignored, status pending
    rd(1, 8'h90, "R9 status first capture");
    rd(1, 8'h77, "R10 count after status");
    // R10: both count and status
    wr(3, 8'hC4);
    set_live(1, 16'h0088);
    rd(1, 8'h50, "R10 status before count");
    rd(1, 8'h77, "R10 latched count");
    rd(1, 8'h88, "R10 released");

    // R11: reprogram clears latch and pointers
    set_live(0, 16'hAAAA);
    wr(3, 8'hC2);  // count+status ch0
    set_live(0, 16'hBBCC);
    wr(0, 8'h01);
    wr(3, 8'h34);
    @(negedge clk);
    chk("R11 wr pointer cleared", {5'd0, wr_byte_hi}, 8'h00);
    rd(0, 8'hCC, "R11 no status, live lsb");
    rd(0, 8'hBB, "R11 live msb");

    // R12: control address read
    rd(3, 8'h00, "R12 control read zero");
    rd(0, 8'hCC, "R12 no state change");
    rd(0, 8'hBB, "R12 no state change msb");

    repeat (4) @(negedge clk);
    chk("R12 all responses seen", 8'(q_exp.size()), 8'h00);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule